// File: doc/BRIEF.md
# Dual-Mode Seven-Segment Display Driver

This block drives a four-digit, common-anode seven-segment display in one of two modes, chosen by a fail flag. When the flag is low, a 4-bit binary value is decoded to its hexadecimal glyph and shown on the leftmost digit only. When the flag is high, the four digits are scanned one at a time to spell the word FAIL. Each scan step is paced by a refresh tick enable, which is normally a strobe of about 1 kHz from a prescaler, so all four letters appear lit at once.

Both modes compute their next outputs in one combinational process, and one register stage stores them. Each segment and digit-select output therefore has exactly one driver, and there is no combinational loop between the two modes. All outputs are registered and active-low. A synchronous reset blanks the display until the first refresh tick arrives.

Top module: `sseg_dual_driver`

## Requirements
- R1: At most one digit select is low in any cycle. Selects are active-low, so 4'b1111 means all digits are off.
- R2: Segment outputs are active-low, with bit 0 = segment a and bit 6 = segment g. In number mode the value 0..F is shown as 40,79,24,30,19,12,02,78,00,10,08,03,46,21,06,0E (hex, in order of value).
- R3: With the fail flag high, the outputs change only in a cycle whose clock edge sees the tick high. With no tick they hold their values.
- R4: A synchronous reset sets the selects to 4'b1111 and the segments to 7'h7F. Both stay at those values until the first clock edge that sees the tick high.
- R5: In number mode, once started, the select is 4'b0111 and the segments show the glyph of the value sampled at the previous clock edge. The outputs follow the value every clock, with or without a tick.
- R6: In message mode the digits show F (0E) on select 4'b0111, A (08) on 4'b1011, I (79) on 4'b1101 and L (47) on 4'b1110.
- R7: Successive ticks in message mode visit the digits in the order left, mid-left, mid-right, right, and then return to left.
- R8: When the flag falls, number mode is shown from the next clock. Each new entry into message mode starts its scan at the left digit.
- R9: A reset asserted in the middle of operation returns the block to the blanked state of R4, whatever mode it was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Refresh strobe, one clock wide |
| fail_i | input | 1 | High selects message mode, low selects number mode |
| value_i | input | 4 | Binary value for number mode |
| seg_o | output | 7 | Segment lines, active-low, bit 0 = a |
| sel_o | output | 4 | Digit selects, active-low, bit 3 = leftmost |

## Verification
The properties assume that the fail flag and the tick are sampled as clean synchronous levels. They also assume that nothing the block does depends on the tick rate, so the stimulus raises the tick only between runs of idle cycles. The glyph property looks at the cycle after a message-mode tick. The bench never changes the fail flag and raises the tick in the same cycle except when entering message mode, and there the scan start is what the check is about. The value input is swept over all 16 codes while the flag is low and is left untouched during message-mode scans.

// File: rtl/sseg_pkg.sv
package sseg_pkg;
    localparam int SEG_W   = 7;
    localparam int NUM_DIG = 4;
    localparam int VAL_W   = 4;
    localparam int POS_W   = $clog2(NUM_DIG);

    typedef logic [SEG_W-1:0]   seg_t;
    typedef logic [NUM_DIG-1:0] sel_t;
    typedef logic [POS_W-1:0]   pos_t;
    typedef logic [VAL_W-1:0]   val_t;

    localparam seg_t SEG_BLANK = '1;
    localparam sel_t SEL_NONE  = '1;
    localparam pos_t POS_LAST  = pos_t'(NUM_DIG - 1);

    typedef struct packed {
        logic started;
        pos_t pos;
        seg_t seg;
        sel_t sel;
    } drv_state_t;

    // Active-low one-hot select; position 0 is the leftmost (MSB) digit.
    function automatic sel_t sel_for(input pos_t p);
        sel_t onehot;
        onehot = '0;
        onehot[NUM_DIG-1-int'(p)] = 1'b1;
        return ~onehot;
    endfunction
endpackage

// File: rtl/sseg_hex_decode.sv
module sseg_hex_decode
    import sseg_pkg::*;
(
    input  val_t value_i,
    output seg_t seg_o
);
    // Active-low patterns, bit 6 = g ... bit 0 = a.
    always_comb begin
        unique case (value_i)
            4'h0: seg_o = 7'h40;
            4'h1: seg_o = 7'h79;
            4'h2: seg_o = 7'h24;
            4'h3: seg_o = 7'h30;
            4'h4: seg_o = 7'h19;
            4'h5: seg_o = 7'h12;
            4'h6: seg_o = 7'h02;
            4'h7: seg_o = 7'h78;
            4'h8: seg_o = 7'h00;
            4'h9: seg_o = 7'h10;
            4'hA: seg_o = 7'h08;
            4'hB: seg_o = 7'h03;
            4'hC: seg_o = 7'h46;
            4'hD: seg_o = 7'h21;
            4'hE: seg_o = 7'h06;
            default: seg_o = 7'h0E;
        endcase
    end
endmodule

// File: rtl/sseg_msg_glyph.sv
module sseg_msg_glyph
    import sseg_pkg::*;
(
    input  pos_t pos_i,
    output seg_t seg_o
);
    // Letters of the fixed word, leftmost first.
    always_comb begin
        unique case (pos_i)
            2'd0: seg_o = 7'h0E;   // F
            2'd1: seg_o = 7'h08;   // A
            2'd2: seg_o = 7'h79;   // I
            default: seg_o = 7'h47; // L
        endcase
    end
endmodule

// File: rtl/sseg_dual_driver.sv
module sseg_dual_driver
    import sseg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       fail_i,
    input  logic [3:0] value_i,
    output logic [6:0] seg_o,
    output logic [3:0] sel_o
);
    drv_state_t st_d, st_q;
    seg_t       hex_seg;
    seg_t       msg_seg;

    sseg_hex_decode u_hex (
        .value_i (value_i),
        .seg_o   (hex_seg)
    );

    sseg_msg_glyph u_msg (
        .pos_i (st_q.pos),
        .seg_o (msg_seg)
    );

    // Single next-state process: both modes feed the same registers.
    always_comb begin
        st_d = st_q;
        if (fail_i) begin
            if (tick_i) begin
                st_d.started = 1'b1;
                st_d.seg     = msg_seg;
                st_d.sel     = sel_for(st_q.pos);
                st_d.pos     = (st_q.pos == POS_LAST) ? '0 : st_q.pos + pos_t'(1);
            end
        end else begin
            st_d.pos = '0;
            if (tick_i || st_q.started) begin
                st_d.started = 1'b1;
                st_d.seg     = hex_seg;
                st_d.sel     = sel_for('0);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{started: 1'b0, pos: '0, seg: SEG_BLANK, sel: SEL_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o = st_q.seg;
    assign sel_o = st_q.sel;
endmodule

// File: rtl/sseg_dual_driver_chk.sv
module sseg_dual_driver_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       tick_i,
    input logic       fail_i,
    input logic [6:0] seg_o,
    input logic [3:0] sel_o
);
    logic seen_tick_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       seen_tick_q <= 1'b0;
        else if (tick_i) seen_tick_q <= 1'b1;
    end

    function automatic logic [6:0] letter_at(input logic [3:0] s);
        case (s)
            4'b0111: return 7'h0E;
            4'b1011: return 7'h08;
            4'b1101: return 7'h79;
            default: return 7'h47;
        endcase
    endfunction

    AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(~sel_o)); // R1

    AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        (fail_i && !tick_i) |=> ($stable(sel_o) && $stable(seg_o))); // R3

    AST_BLANK_UNTIL_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        !seen_tick_q |-> (sel_o == 4'hF && seg_o == 7'h7F)); // R4

    AST_NUM_LEFT_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && !$past(fail_i) && sel_o != 4'hF) |-> sel_o == 4'b0111); // R5

    AST_MSG_GLYPH: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && $past(fail_i) && $past(tick_i)) |-> seg_o == letter_at(sel_o)); // R6
endmodule

bind sseg_dual_driver sseg_dual_driver_chk chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (tick_i),
    .fail_i (fail_i),
    .seg_o  (seg_o),
    .sel_o  (sel_o)
);

// File: tb/sseg_dual_driver_tb_top.sv
module sseg_dual_driver_tb_top;
    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       fail_i = 1'b0;
    logic [3:0] value_i = '0;
    logic [6:0] seg_o;
    logic [3:0] sel_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sseg_dual_driver dut_i (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .tick_i  (tick_i),
        .fail_i  (fail_i),
        .value_i (value_i),
        .seg_o   (seg_o),
        .sel_o   (sel_o)
    );

    // Lit-segment masks (active-high, bit 0 = a), inverted for the pins.
    function automatic logic [6:0] hex_exp(input int v);
        logic [6:0] lit;
        case (v)
            0: lit = 7'h3F;  1: lit = 7'h06;  2: lit = 7'h5B;  3: lit = 7'h4F;
            4: lit = 7'h66;  5: lit = 7'h6D;  6: lit = 7'h7D;  7: lit = 7'h07;
            8: lit = 7'h7F;  9: lit = 7'h6F; 10: lit = 7'h77; 11: lit = 7'h7C;
            12: lit = 7'h39; 13: lit = 7'h5E; 14: lit = 7'h79; default: lit = 7'h71;
        endcase
        return ~lit;
    endfunction

    function automatic logic [6:0] let_exp(input int p);
        logic [6:0] lit;
        case (p)
            0: lit = 7'h71;          // F: a e f g
            1: lit = 7'h77;          // A
            2: lit = 7'h06;          // I: b c
            default: lit = 7'h38;    // L: d e f
        endcase
        return ~lit;
    endfunction

    function automatic logic [3:0] sel_exp(input int p);
        return ~(4'b1000 >> p);
    endfunction

    task automatic cyc(input logic r, input logic t, input logic f, input logic [3:0] v);
        @(negedge clk);
        rst_i = r; tick_i = t; fail_i = f; value_i = v;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [6:0] es, input logic [3:0] el);
        n_vec++;
        if (seg_o !== es || sel_o !== el) begin
            n_bad++;
            $display("FAIL %s: seg=%h sel=%b expected seg=%h sel=%b", req, seg_o, sel_o, es, el);
        end
        n_vec++;
        if ($countones(~sel_o) > 1) begin
            n_bad++;
            $display("FAIL R1: sel=%b expected at most one low", sel_o);
        end
    endtask

    initial begin
        cyc(1, 0, 0, 4'h5);
        cyc(1, 0, 0, 4'h5);
        cyc(0, 0, 0, 4'h5);
        chk("R4", 7'h7F, 4'hF);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, i[0], 4'(i + 3));
            chk("R4", 7'h7F, 4'hF);
        end
        // first tick in number mode starts the display
        cyc(0, 1, 0, 4'h0);
        chk("R5", hex_exp(0), 4'b0111);
        for (int v = 0; v < 16; v++) begin
            cyc(0, 0, 0, 4'(v));
            chk("R2", hex_exp(v), 4'b0111);
        end
        // message mode, no tick: hold last number glyph
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 1, 4'h3);
            chk("R3", hex_exp(15), 4'b0111);
        end
        for (int k = 0; k < 9; k++) begin
            cyc(0, 1, 1, 4'h3);
            chk("R7", let_exp(k % 4), sel_exp(k % 4));
            for (int j = 0; j < 2; j++) begin
                cyc(0, 0, 1, 4'h3);
                chk("R3", let_exp(k % 4), sel_exp(k % 4));
            end
        end
        chk("R6", let_exp(0), 4'b0111);
        // scan is now mid-way; leave message mode
        cyc(0, 0, 0, 4'hA);
        chk("R8", hex_exp(10), 4'b0111);
        cyc(0, 0, 0, 4'h7);
        chk("R8", hex_exp(7), 4'b0111);
        // re-entry restarts at left
        cyc(0, 1, 1, 4'h7);
        chk("R8", let_exp(0), sel_exp(0));
        cyc(0, 1, 1, 4'h7);
        chk("R6", let_exp(1), sel_exp(1));
        // reset in the middle of a scan
        cyc(1, 1, 1, 4'h7);
        chk("R9", 7'h7F, 4'hF);
        cyc(0, 0, 1, 4'h7);
        chk("R9", 7'h7F, 4'hF);
        cyc(0, 0, 0, 4'h2);
        chk("R4", 7'h7F, 4'hF);
        cyc(0, 1, 1, 4'h2);
        chk("R8", let_exp(0), sel_exp(0));
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule